// File: doc/BRIEF.md
# Consumer Channel-Status and User Block Collector

This block sits behind a biphase subframe decoder in a digital audio receiver. For each decoded subframe it gets one strobe together with the subframe's channel-status bit, its user bit, a flag that says which channel the subframe belongs to, and a flag for the block-start preamble. A block is 192 frames long, and each frame holds one channel-A subframe followed by one channel-B subframe. In consumer mode only the first 40 frames of a block carry status and user information. The collector keeps four 40-bit words: status for A, status for B, user for A and user for B. It gathers the bits of frames 0 to 39 into these words and discards the bits of frames 40 to 191.

The block locks onto the first block-start preamble it sees. When the channel-B subframe of frame 39 has been taken in, it publishes all four words at once and raises a one-cycle ready strobe. It checks the block length. A preamble that arrives early restarts the count and raises a block error. A block that runs past 192 frames with no preamble raises a sync-lost error and drops lock, and the published words stay as they were.

Top module: `cs_user_collector`

## Requirements
- R1: During reset and in the first cycle after it, all four published words are zero and `words_rdy`, `block_err` and `sync_lost` are low.
- R2: Before the first block-start, and after sync has been lost, subframes change no published word and raise no strobe. They are ignored until a channel-A subframe arrives with `sf_blk_start` high.
- R3: Frame n (0..39) of the current block puts its channel-status bit at bit index n of `status_a` or `status_b`, and its user bit at bit index n of `user_a` or `user_b`. The word is chosen by `sf_chan_b` (0 = A, 1 = B).
- R4: `words_rdy` is high for exactly one cycle, the clock after the channel-B subframe of frame 39 is accepted. All four words take their new values on that same edge.
- R5: Bits carried in frames 40 to 191 have no effect on any published word.
- R6: If a channel-A subframe with `sf_blk_start` arrives while locked and the frame count is not 192, `block_err` pulses for one cycle on the next clock. That subframe then counts as frame 0 of a new block.
- R7: If a channel-A subframe without `sf_blk_start` arrives while locked and 192 frames have already been counted, `sync_lost` pulses for one cycle on the next clock. Lock is dropped and the published words are held.
- R8: A block-start that arrives exactly after 192 frames raises no error, and the new block is gathered and published normally.
- R9: `sf_blk_start` on a channel-B subframe is ignored, and that subframe is handled as an ordinary channel-B subframe.
- R10: Between `words_rdy` pulses the published words do not change.
- R11: Cycles with `sf_valid` low have no effect on counting, capture or strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_valid | input | 1 | One-cycle strobe: a decoded subframe is present |
| sf_blk_start | input | 1 | Subframe carried the block-start preamble |
| sf_chan_b | input | 1 | 0 = channel-A subframe, 1 = channel-B subframe |
| sf_cbit | input | 1 | Channel-status bit of the subframe |
| sf_ubit | input | 1 | User bit of the subframe |
| status_a | output | 40 | Published channel-status word, channel A |
| status_b | output | 40 | Published channel-status word, channel B |
| user_a | output | 40 | Published user word, channel A |
| user_b | output | 40 | Published user word, channel B |
| words_rdy | output | 1 | One-cycle strobe: new words published |
| block_err | output | 1 | One-cycle strobe: block-start at the wrong frame count |
| sync_lost | output | 1 | One-cycle strobe: 192 frames passed with no block-start |

## Verification
An internal frame count that is off by one shows up at the ports right away. The ready strobe moves to a different subframe, and the published words come out shifted by one bit position the first time they are published. A lock flag in the wrong state either suppresses publishing or lets bits from before lock was gained reach the words. A wrong terminal count makes a correct 192-frame block raise `block_err` or `sync_lost` at the next preamble. The directed tests compare every published word bit by bit against words the bench builds from its own bit patterns. They also count each strobe around aligned block-starts, early block-starts, missing block-starts, misplaced block-starts, and idle gaps between subframes.

// File: rtl/cs_collect_pkg.sv
package cs_collect_pkg;

    localparam int unsigned DEF_BLOCK_FRAMES = 192;
    localparam int unsigned DEF_USED_FRAMES  = 40;
    localparam int unsigned NUM_LANES        = 4;

    typedef enum logic [1:0] {
        LANE_CS_A = 2'd0,
        LANE_CS_B = 2'd1,
        LANE_UD_A = 2'd2,
        LANE_UD_B = 2'd3
    } lane_e;

    typedef struct packed {
        logic valid;
        logic blk_start;
        logic chan_b;
        logic cbit;
        logic ubit;
    } subframe_t;

    typedef struct packed {
        logic cap_a;
        logic cap_b;
        logic publish;
        logic blk_err;
        logic sync_err;
    } seq_ctl_t;

    function automatic logic lane_is_b(lane_e l);
        return (l == LANE_CS_B) || (l == LANE_UD_B);
    endfunction

    function automatic logic lane_is_user(lane_e l);
        return (l == LANE_UD_A) || (l == LANE_UD_B);
    endfunction

endpackage

// File: rtl/csu_frame_seq.sv
module csu_frame_seq
    import cs_collect_pkg::*;
#(
    parameter int unsigned BLOCK_FRAMES = DEF_BLOCK_FRAMES,
    parameter int unsigned USED_FRAMES  = DEF_USED_FRAMES,
    parameter int unsigned CNT_W        = $clog2(BLOCK_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  subframe_t        sf,
    output seq_ctl_t         ctl,
    output logic [CNT_W-1:0] frame_cnt
);

    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(BLOCK_FRAMES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(USED_FRAMES - 1);
    localparam logic [CNT_W-1:0] CNT_USED = CNT_W'(USED_FRAMES);

    logic             locked_q;
    logic [CNT_W-1:0] cnt_q;
    logic             a_sf, b_sf, start_sf, in_used;

    always_comb begin
        a_sf     = sf.valid && !sf.chan_b;
        b_sf     = sf.valid && sf.chan_b;
        start_sf = a_sf && sf.blk_start;
        in_used  = cnt_q < CNT_USED;

        ctl.cap_a    = start_sf || (a_sf && locked_q && in_used);
        ctl.cap_b    = b_sf && locked_q && in_used;
        ctl.publish  = b_sf && locked_q && (cnt_q == CNT_LAST);
        ctl.blk_err  = start_sf && locked_q && (cnt_q != CNT_END);
        ctl.sync_err = a_sf && !sf.blk_start && locked_q && (cnt_q == CNT_END);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start_sf) begin
            locked_q <= 1'b1;
            cnt_q    <= '0;
        end else if (ctl.sync_err) begin
            locked_q <= 1'b0;
        end else if (b_sf && locked_q && (cnt_q != CNT_END)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign frame_cnt = cnt_q;

endmodule

// File: rtl/csu_lane.sv
module csu_lane #(
    parameter int unsigned W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word_d
);

    logic [W-1:0] word_q;

    // New bits enter at the top; after W shifts the first bit sits at index 0.
    always_comb word_d = shift_en ? {bit_in, word_q[W-1:1]} : word_q;

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

endmodule

// File: rtl/csu_publish.sv
module csu_publish
    import cs_collect_pkg::*;
#(
    parameter int unsigned W = DEF_USED_FRAMES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  seq_ctl_t                      ctl,
    input  logic [NUM_LANES-1:0][W-1:0]   next_words,
    output logic [NUM_LANES-1:0][W-1:0]   pub_words,
    output logic                          rdy,
    output logic                          berr,
    output logic                          slost
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pub_words <= '0;
            rdy       <= 1'b0;
            berr      <= 1'b0;
            slost     <= 1'b0;
        end else begin
            if (ctl.publish) pub_words <= next_words;
            rdy   <= ctl.publish;
            berr  <= ctl.blk_err;
            slost <= ctl.sync_err;
        end
    end

endmodule

// File: rtl/cs_user_collector.sv
module cs_user_collector
    import cs_collect_pkg::*;
#(
    parameter int unsigned BLOCK_FRAMES = DEF_BLOCK_FRAMES,
    parameter int unsigned USED_FRAMES  = DEF_USED_FRAMES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sf_valid,
    input  logic                   sf_blk_start,
    input  logic                   sf_chan_b,
    input  logic                   sf_cbit,
    input  logic                   sf_ubit,
    output logic [USED_FRAMES-1:0] status_a,
    output logic [USED_FRAMES-1:0] status_b,
    output logic [USED_FRAMES-1:0] user_a,
    output logic [USED_FRAMES-1:0] user_b,
    output logic                   words_rdy,
    output logic                   block_err,
    output logic                   sync_lost
);

    localparam int unsigned W     = USED_FRAMES;
    localparam int unsigned CNT_W = $clog2(BLOCK_FRAMES + 1);

    subframe_t                     sf;
    seq_ctl_t                      ctl;
    logic [CNT_W-1:0]              frame_cnt;
    logic [NUM_LANES-1:0]          lane_en;
    logic [NUM_LANES-1:0]          lane_bit;
    logic [NUM_LANES-1:0][W-1:0]   next_words;
    logic [NUM_LANES-1:0][W-1:0]   pub_words;

    always_comb begin
        sf.valid     = sf_valid;
        sf.blk_start = sf_blk_start;
        sf.chan_b    = sf_chan_b;
        sf.cbit      = sf_cbit;
        sf.ubit      = sf_ubit;
    end

    csu_frame_seq #(
        .BLOCK_FRAMES(BLOCK_FRAMES),
        .USED_FRAMES (USED_FRAMES),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .sf       (sf),
        .ctl      (ctl),
        .frame_cnt(frame_cnt)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam lane_e LID = lane_e'(g);
        assign lane_en[g]  = lane_is_b(LID) ? ctl.cap_b : ctl.cap_a;
        assign lane_bit[g] = lane_is_user(LID) ? sf.ubit : sf.cbit;

        csu_lane #(.W(W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .shift_en(lane_en[g]),
            .bit_in  (lane_bit[g]),
            .word_d  (next_words[g])
        );
    end

    csu_publish #(.W(W)) u_pub (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .next_words(next_words),
        .pub_words (pub_words),
        .rdy       (words_rdy),
        .berr      (block_err),
        .slost     (sync_lost)
    );

    assign status_a = pub_words[LANE_CS_A];
    assign status_b = pub_words[LANE_CS_B];
    assign user_a   = pub_words[LANE_UD_A];
    assign user_b   = pub_words[LANE_UD_B];

endmodule

// File: rtl/cs_user_collector_chk.sv
module cs_user_collector_chk #(
    parameter int unsigned BLOCK_FRAMES = 192,
    parameter int unsigned USED_FRAMES  = 40,
    parameter int unsigned CNT_W        = $clog2(BLOCK_FRAMES + 1)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sf_valid,
    input logic                   sf_blk_start,
    input logic                   sf_chan_b,
    input logic [USED_FRAMES-1:0] status_a,
    input logic [USED_FRAMES-1:0] status_b,
    input logic [USED_FRAMES-1:0] user_a,
    input logic [USED_FRAMES-1:0] user_b,
    input logic                   words_rdy,
    input logic                   block_err,
    input logic                   sync_lost,
    input logic [CNT_W-1:0]       frame_cnt
);

    p_rdy_after_b_r4: assert property (@(posedge clk) disable iff (rst)
        words_rdy |-> $past(sf_valid && sf_chan_b));

    p_hold_words_r10: assert property (@(posedge clk) disable iff (rst)
        !words_rdy |-> ($stable(status_a) && $stable(status_b) &&
                        $stable(user_a) && $stable(user_b)));

    p_blkerr_cause_r6: assert property (@(posedge clk) disable iff (rst)
        block_err |-> $past(sf_valid && sf_blk_start && !sf_chan_b));

    p_synclost_cause_r7: assert property (@(posedge clk) disable iff (rst)
        sync_lost |-> $past(sf_valid && !sf_blk_start && !sf_chan_b));

    p_err_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(block_err && sync_lost) && !(words_rdy && block_err));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !sf_valid |=> (!words_rdy && !block_err && !sync_lost));

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        frame_cnt <= CNT_W'(BLOCK_FRAMES));

endmodule

bind cs_user_collector cs_user_collector_chk #(
    .BLOCK_FRAMES(BLOCK_FRAMES),
    .USED_FRAMES (USED_FRAMES)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .sf_valid    (sf_valid),
    .sf_blk_start(sf_blk_start),
    .sf_chan_b   (sf_chan_b),
    .status_a    (status_a),
    .status_b    (status_b),
    .user_a      (user_a),
    .user_b      (user_b),
    .words_rdy   (words_rdy),
    .block_err   (block_err),
    .sync_lost   (sync_lost),
    .frame_cnt   (frame_cnt)
);

// File: tb/cs_user_collector_tb.sv
module cs_user_collector_tb_top;

    localparam int W  = 40;
    localparam int BF = 192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sf_valid = 1'b0, sf_blk_start = 1'b0, sf_chan_b = 1'b0;
    logic sf_cbit = 1'b0, sf_ubit = 1'b0;
    logic [W-1:0] status_a, status_b, user_a, user_b;
    logic words_rdy, block_err, sync_lost;

    int errors = 0;
    int checks = 0;
    int rdy_n = 0, berr_n = 0, slost_n = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cs_user_collector dut_i (
        .clk(clk), .rst(rst),
        .sf_valid(sf_valid), .sf_blk_start(sf_blk_start), .sf_chan_b(sf_chan_b),
        .sf_cbit(sf_cbit), .sf_ubit(sf_ubit),
        .status_a(status_a), .status_b(status_b), .user_a(user_a), .user_b(user_b),
        .words_rdy(words_rdy), .block_err(block_err), .sync_lost(sync_lost)
    );

    always @(negedge clk) begin
        if (words_rdy) rdy_n++;
        if (block_err) berr_n++;
        if (sync_lost) slost_n++;
    end

    // Lane order: 0 status A, 1 status B, 2 user A, 3 user B
    function automatic logic gen(int seed, int lane, int f);
        int v;
        v = f * 13 + seed * 29 + lane * 7 + (f * f) % 5;
        return v[2] ^ v[0];
    endfunction

    function automatic logic [W-1:0] exp_word(int seed, int lane);
        logic [W-1:0] w;
        for (int f = 0; f < W; f++) w[f] = gen(seed, lane, f);
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_words(input string req, input int seed);
        chk(status_a == exp_word(seed, 0), {req, " status_a"}, status_a, exp_word(seed, 0));
        chk(status_b == exp_word(seed, 1), {req, " status_b"}, status_b, exp_word(seed, 1));
        chk(user_a   == exp_word(seed, 2), {req, " user_a"},   user_a,   exp_word(seed, 2));
        chk(user_b   == exp_word(seed, 3), {req, " user_b"},   user_b,   exp_word(seed, 3));
    endtask

    task automatic sub(input logic chb, input logic st, input logic c, input logic u);
        sf_valid = 1'b1; sf_chan_b = chb; sf_blk_start = st; sf_cbit = c; sf_ubit = u;
        @(negedge clk);
        sf_valid = 1'b0; sf_blk_start = 1'b0;
    endtask

    task automatic send_block(input int seed, input int nframes, input bit with_start,
                              input int b_start_frame, input int gap, input bit check_pub,
                              input string req);
        for (int f = 0; f < nframes; f++) begin
            sub(1'b0, with_start && (f == 0), gen(seed, 0, f), gen(seed, 2, f));
            repeat (gap) @(negedge clk);
            sub(1'b1, f == b_start_frame, gen(seed, 1, f), gen(seed, 3, f));
            if (check_pub && f == W - 1) begin
                chk(words_rdy == 1'b1, {req, " R4 ready after frame 39 B"}, W'(words_rdy), W'(1));
                chk_words({req, " R3 packing"}, seed);
                @(negedge clk);
                chk(words_rdy == 1'b0, {req, " R4 single-cycle ready"}, W'(words_rdy), W'(0));
            end
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk((status_a | status_b | user_a | user_b) == '0, "R1 words zero", status_a | status_b | user_a | user_b, '0);
        chk(!(words_rdy || block_err || sync_lost), "R1 strobes low",
            W'({words_rdy, block_err, sync_lost}), W'(0));
    endtask

    task automatic t_unlocked();
        int r0 = rdy_n, b0 = berr_n, s0 = slost_n;
        send_block(9, 50, 1'b0, -1, 0, 1'b0, "R2");
        settle();
        chk(rdy_n == r0 && berr_n == b0 && slost_n == s0, "R2 no strobes before lock",
            W'(rdy_n - r0 + berr_n - b0 + slost_n - s0), W'(0));
        chk((status_a | status_b | user_a | user_b) == '0, "R2 words untouched",
            status_a | status_b | user_a | user_b, '0);
    endtask

    task automatic t_first_block();
        int r0 = rdy_n;
        send_block(1, BF, 1'b1, -1, 0, 1'b1, "R3/R4 block1");
        settle();
        chk(rdy_n == r0 + 1, "R4 one ready per block", W'(rdy_n - r0), W'(1));
        chk_words("R5/R10 frames 40-191 ignored", 1);
    endtask

    task automatic t_aligned_gapped();
        int b0 = berr_n;
        send_block(2, BF, 1'b1, -1, 2, 1'b1, "R8/R11 gapped");
        settle();
        chk(berr_n == b0, "R8 aligned start no error", W'(berr_n - b0), W'(0));
        chk_words("R11 idle gaps no effect", 2);
    endtask

    task automatic t_early_start();
        int b0 = berr_n;
        send_block(3, 100, 1'b1, -1, 0, 1'b1, "R6 short block");
        send_block(4, BF, 1'b1, -1, 0, 1'b1, "R6 restart");
        settle();
        chk(berr_n == b0 + 1, "R6 early start flags block_err", W'(berr_n - b0), W'(1));
    endtask

    task automatic t_b_start_flag();
        int b0 = berr_n;
        send_block(5, BF, 1'b1, 5, 0, 1'b1, "R9 start on B");
        settle();
        chk(berr_n == b0, "R9 start flag on B ignored", W'(berr_n - b0), W'(0));
    endtask

    task automatic t_sync_loss();
        int r0 = rdy_n, s0 = slost_n, b0 = berr_n;
        send_block(6, 60, 1'b0, -1, 0, 1'b0, "R7");
        settle();
        chk(slost_n == s0 + 1, "R7 sync_lost once", W'(slost_n - s0), W'(1));
        chk(rdy_n == r0 && berr_n == b0, "R7 no ready or block_err while unlocked",
            W'(rdy_n - r0 + berr_n - b0), W'(0));
        chk_words("R7 words held", 5);
        send_block(7, 45, 1'b1, -1, 0, 1'b1, "R2/R7 reacquire");
        settle();
        chk(berr_n == b0, "R2 reacquire no block_err", W'(berr_n - b0), W'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_unlocked();
        t_first_block();
        t_aligned_gapped();
        t_early_start();
        t_b_start_flag();
        t_sync_loss();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule